// File: doc/BRIEF.md
# Load Hit/Miss Predictor with Issue Replay

This block sits beside an out-of-order integer issue stage. It decides, for every integer load at issue, whether the load's consumers may be woken speculatively at the cache-hit latency. When a load that was allowed to wake its consumers early turns out to miss, the block squashes the shadowed issue cycles.

The decision comes from a table of 2-bit saturating counters indexed by the load's instruction address. Each load carries a small in-flight tag. At issue, the block records the prediction and the table index under that tag. When the cache reports the outcome (up to two loads per cycle), the block looks up the tag, trains the counter, and decides whether a replay is needed. For every load it also reports the latency its consumers should assume: 3 cycles when early wakeup is allowed, 5 cycles when it is not.

Top module: `lhm_predictor`

## Requirements
- R1: After reset every counter holds the weak-hit value 2 (binary 10), so the first issue of any address predicts a hit.
- R2: The table index is instruction address bits [IDX_W+1:2]. `spec_wake_o` is high in a cycle exactly when `iss_vld_i` is high and the indexed counter has its upper bit set (value 2 or 3).
- R3: When `spec_wake_o` is high, `lat_o` equals 3.
- R4: When `iss_vld_i` is high and the prediction is a miss (counter 0 or 1), `spec_wake_o` is low and `lat_o` equals 5. `lat_o` is 0 when no load issues.
- R5: A resolved hit adds one to the counter of the load's index, saturating at 3. A resolved miss subtracts one, saturating at 0.
- R6: Two resolution lanes are accepted per cycle and both take effect. When both name loads with the same index, lane 0 is applied first and lane 1 is applied to its result. The two lanes never carry the same tag.
- R7: A load that was predicted to hit and resolves as a miss raises `replay_o` for exactly two consecutive cycles, starting in the cycle after the outcome is presented.
- R8: A miss on a load predicted to miss, and any hit, cause no replay.
- R9: A further mispredicted miss while `replay_o` is high restarts the two-cycle window from its own outcome cycle.
- R10: The replay decision uses the prediction made when the load issued, not the counter value at resolution time.
- R11: An issue in the same cycle as counter updates sees the counter value from before those updates.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| iss_vld_i | input | 1 | A load issues this cycle |
| iss_pc_i | input | PC_W | Instruction address of the issuing load |
| iss_tag_i | input | TAG_W | In-flight tag given to the issuing load |
| spec_wake_o | output | 1 | Consumers of this load may be woken at hit latency |
| lat_o | output | LAT_W | Latency consumers should assume (3 or 5, 0 when idle) |
| res_vld_i | input | N_RES | Per lane: a load outcome is presented |
| res_tag_i | input | N_RES*TAG_W | Per lane: tag of the resolving load |
| res_hit_i | input | N_RES | Per lane: 1 for a cache hit, 0 for a miss |
| replay_o | output | 1 | High for each shadowed issue cycle to squash and reissue |

## Verification
The bench goes after the counter edges: saturation at 0 and 3, and the crossing between 1 and 2 that flips the wakeup decision. A design that wrapped a counter would predict a hit right after a run of misses. A design with the wrong threshold would report latency 3 for a load that will not wake its consumers. Dual-lane updates to one entry are driven on purpose. A table that let lane 1 overwrite lane 0 would lose one step of training and drift from the model. The replay window is checked for its exact length, for a restart by a back-to-back mispredict, and for the case where the counter changed between issue and resolution. A design that read the live counter at resolution would replay loads that were predicted to miss, or skip loads that were predicted to hit.

// File: rtl/lhm_pkg.sv
package lhm_pkg;

  typedef logic [1:0] ctr_t;

  localparam ctr_t CTR_WEAK_HIT = 2'b10;
  localparam ctr_t CTR_MAX      = 2'b11;
  localparam ctr_t CTR_MIN      = 2'b00;

  // one training step of a 2-bit saturating counter
  function automatic ctr_t ctr_step(input ctr_t cur, input logic hit);
    ctr_t nxt;
    if (hit) nxt = (cur == CTR_MAX) ? cur : cur + 2'd1;
    else     nxt = (cur == CTR_MIN) ? cur : cur - 2'd1;
    return nxt;
  endfunction

  function automatic logic ctr_says_hit(input ctr_t cur);
    return cur[1];
  endfunction

endpackage

// File: rtl/lhm_ctr_table.sv
module lhm_ctr_table
  import lhm_pkg::*;
#(
  parameter int IDX_W  = 4,
  parameter int N_PORT = 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [IDX_W-1:0]              rd_idx,
  output ctr_t                          rd_ctr,
  input  logic [N_PORT-1:0]             upd_vld,
  input  logic [N_PORT-1:0][IDX_W-1:0]  upd_idx,
  input  logic [N_PORT-1:0]             upd_hit
);

  localparam int DEPTH = 1 << IDX_W;

  ctr_t ctr_q [DEPTH];
  ctr_t ctr_d [DEPTH];
  logic [DEPTH-1:0] ctr_en;

  for (genvar e = 0; e < DEPTH; e++) begin : g_entry
    // fold the update lanes in lane order
    always_comb begin
      ctr_d[e]  = ctr_q[e];
      ctr_en[e] = 1'b0;
      for (int p = 0; p < N_PORT; p++) begin
        if (upd_vld[p] && (upd_idx[p] == IDX_W'(e))) begin
          ctr_d[e]  = ctr_step(ctr_d[e], upd_hit[p]);
          ctr_en[e] = 1'b1;
        end
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          ctr_q[e] <= CTR_WEAK_HIT;
      else if (ctr_en[e])  ctr_q[e] <= ctr_d[e];
    end
  end

  // read returns the registered value, before this cycle's updates
  assign rd_ctr = ctr_q[rd_idx];

endmodule

// File: rtl/lhm_inflight.sv
module lhm_inflight #(
  parameter int TAG_W = 3,
  parameter int IDX_W = 4,
  parameter int N_RD  = 2
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_vld,
  input  logic [TAG_W-1:0]             wr_tag,
  input  logic [IDX_W-1:0]             wr_idx,
  input  logic                         wr_pred,
  input  logic [N_RD-1:0][TAG_W-1:0]   rd_tag,
  output logic [N_RD-1:0][IDX_W-1:0]   rd_idx,
  output logic [N_RD-1:0]              rd_pred
);

  localparam int SLOTS = 1 << TAG_W;

  logic [IDX_W-1:0] idx_q  [SLOTS];
  logic             pred_q [SLOTS];

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    logic slot_en;
    assign slot_en = wr_vld && (wr_tag == TAG_W'(s));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        idx_q[s]  <= '0;
        pred_q[s] <= 1'b0;
      end else if (slot_en) begin
        idx_q[s]  <= wr_idx;
        pred_q[s] <= wr_pred;
      end
    end
  end

  for (genvar p = 0; p < N_RD; p++) begin : g_rd
    assign rd_idx[p]  = idx_q[rd_tag[p]];
    assign rd_pred[p] = pred_q[rd_tag[p]];
  end

endmodule

// File: rtl/lhm_replay.sv
module lhm_replay #(
  parameter int SHADOW = 2,
  parameter int N_RES  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_RES-1:0] res_vld,
  input  logic [N_RES-1:0] res_hit,
  input  logic [N_RES-1:0] res_pred,
  output logic             replay
);

  localparam int CNT_W = $clog2(SHADOW + 1);

  logic [N_RES-1:0] lane_bad;
  logic             any_bad;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  for (genvar p = 0; p < N_RES; p++) begin : g_lane
    assign lane_bad[p] = res_vld[p] && res_pred[p] && !res_hit[p];
  end
  assign any_bad = |lane_bad;

  always_comb begin
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    if (any_bad) begin
      cnt_d  = CNT_W'(SHADOW);
      cnt_en = 1'b1;
    end else if (cnt_q != '0) begin
      cnt_d  = cnt_q - 1'b1;
      cnt_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign replay = (cnt_q != '0);

endmodule

// File: rtl/lhm_predictor.sv
module lhm_predictor
  import lhm_pkg::*;
#(
  parameter int PC_W     = 32,
  parameter int IDX_W    = 4,
  parameter int TAG_W    = 3,
  parameter int N_RES    = 2,
  parameter int HIT_LAT  = 3,
  parameter int MISS_LAT = 5,
  parameter int SHADOW   = 2,
  parameter int LAT_W    = $clog2(MISS_LAT + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   iss_vld_i,
  input  logic [PC_W-1:0]        iss_pc_i,
  input  logic [TAG_W-1:0]       iss_tag_i,
  output logic                   spec_wake_o,
  output logic [LAT_W-1:0]       lat_o,
  input  logic [N_RES-1:0]       res_vld_i,
  input  logic [N_RES*TAG_W-1:0] res_tag_i,
  input  logic [N_RES-1:0]       res_hit_i,
  output logic                   replay_o
);

  logic [IDX_W-1:0]             iss_idx;
  ctr_t                         iss_ctr;
  logic                         iss_pred;
  logic [N_RES-1:0][TAG_W-1:0]  res_tag;
  logic [N_RES-1:0][IDX_W-1:0]  res_idx;
  logic [N_RES-1:0]             res_pred;
  logic                         unused_pc_bits;

  assign iss_idx        = iss_pc_i[IDX_W+1:2];
  assign unused_pc_bits = ^{iss_pc_i[PC_W-1:IDX_W+2], iss_pc_i[1:0]};

  for (genvar p = 0; p < N_RES; p++) begin : g_unpack
    assign res_tag[p] = res_tag_i[p*TAG_W +: TAG_W];
  end

  lhm_ctr_table #(.IDX_W(IDX_W), .N_PORT(N_RES)) u_table (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_idx  (iss_idx),
    .rd_ctr  (iss_ctr),
    .upd_vld (res_vld_i),
    .upd_idx (res_idx),
    .upd_hit (res_hit_i)
  );

  assign iss_pred = ctr_says_hit(iss_ctr);

  lhm_inflight #(.TAG_W(TAG_W), .IDX_W(IDX_W), .N_RD(N_RES)) u_inflight (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_vld  (iss_vld_i),
    .wr_tag  (iss_tag_i),
    .wr_idx  (iss_idx),
    .wr_pred (iss_pred),
    .rd_tag  (res_tag),
    .rd_idx  (res_idx),
    .rd_pred (res_pred)
  );

  lhm_replay #(.SHADOW(SHADOW), .N_RES(N_RES)) u_replay (
    .clk      (clk),
    .rst_n    (rst_n),
    .res_vld  (res_vld_i),
    .res_hit  (res_hit_i),
    .res_pred (res_pred),
    .replay   (replay_o)
  );

  always_comb begin
    spec_wake_o = iss_vld_i && iss_pred;
    if (!iss_vld_i)    lat_o = '0;
    else if (iss_pred) lat_o = LAT_W'(HIT_LAT);
    else               lat_o = LAT_W'(MISS_LAT);
  end

endmodule

// File: rtl/lhm_predictor_chk.sv
module lhm_predictor_chk #(
  parameter int TAG_W    = 3,
  parameter int N_RES    = 2,
  parameter int HIT_LAT  = 3,
  parameter int MISS_LAT = 5,
  parameter int LAT_W    = 3
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   iss_vld_i,
  input logic                   spec_wake_o,
  input logic [LAT_W-1:0]       lat_o,
  input logic [N_RES-1:0]       res_vld_i,
  input logic [N_RES*TAG_W-1:0] res_tag_i,
  input logic                   replay_o
);

  logic res_any;
  assign res_any = |res_vld_i;

  // R3: an early wakeup always comes with the hit latency
  a_r3_hit_latency: assert property (@(posedge clk) disable iff (!rst_n)
    spec_wake_o |-> (lat_o == LAT_W'(HIT_LAT)));

  // R4: an issued load without early wakeup gets the long latency
  a_r4_miss_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_vld_i && !spec_wake_o) |-> (lat_o == LAT_W'(MISS_LAT)));

  // R2: no wakeup without an issuing load
  a_r2_wake_needs_issue: assert property (@(posedge clk) disable iff (!rst_n)
    spec_wake_o |-> iss_vld_i);

  // R7: a replay window lasts at least two cycles
  a_r7_window_two: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(replay_o) |=> replay_o);

  // R8: a replay only starts after an outcome was presented
  a_r8_replay_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(replay_o) |-> $past(res_any));

  // R9: a third replay cycle needs a fresh outcome inside the window
  a_r9_window_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (replay_o && $past(replay_o) && $past(replay_o, 2)) |->
      ($past(res_any) || $past(res_any, 2)));

  // R6: the two lanes never carry the same tag
  if (N_RES >= 2) begin : g_lanes
    a_r6_distinct_tags: assert property (@(posedge clk) disable iff (!rst_n)
      (res_vld_i[0] && res_vld_i[1]) |->
        (res_tag_i[0 +: TAG_W] != res_tag_i[TAG_W +: TAG_W]));
  end

endmodule

bind lhm_predictor lhm_predictor_chk #(
  .TAG_W(TAG_W), .N_RES(N_RES), .HIT_LAT(HIT_LAT),
  .MISS_LAT(MISS_LAT), .LAT_W(LAT_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .iss_vld_i   (iss_vld_i),
  .spec_wake_o (spec_wake_o),
  .lat_o       (lat_o),
  .res_vld_i   (res_vld_i),
  .res_tag_i   (res_tag_i),
  .replay_o    (replay_o)
);

// File: tb/tb_lhm_predictor.sv
module tb_lhm_predictor;

  localparam int PC_W  = 32;
  localparam int IDX_W = 4;
  localparam int TAG_W = 3;
  localparam int LAT_W = 3;

  logic                 clk = 1'b0;
  logic                 rst_n;
  logic                 iss_vld_i;
  logic [PC_W-1:0]      iss_pc_i;
  logic [TAG_W-1:0]     iss_tag_i;
  logic                 spec_wake_o;
  logic [LAT_W-1:0]     lat_o;
  logic [1:0]           res_vld_i;
  logic [2*TAG_W-1:0]   res_tag_i;
  logic [1:0]           res_hit_i;
  logic                 replay_o;

  int n_chk = 0;
  int n_bad = 0;

  int mctr  [16];
  int mpred [8];
  int midx  [8];
  int mrep  = 0;
  logic [15:0] lfsr = 16'hACE1;

  always #10 clk = ~clk;

  lhm_predictor dut (
    .clk(clk), .rst_n(rst_n), .iss_vld_i(iss_vld_i), .iss_pc_i(iss_pc_i),
    .iss_tag_i(iss_tag_i), .spec_wake_o(spec_wake_o), .lat_o(lat_o),
    .res_vld_i(res_vld_i), .res_tag_i(res_tag_i), .res_hit_i(res_hit_i),
    .replay_o(replay_o)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s at %0t: actual %0d expected %0d", req, $time, act, exp);
    end
  endtask

  function automatic void lfsr_step();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
  endfunction

  // one cycle: drive after falling edge, compare, then advance the model
  task automatic cyc(input bit first, input logic iv, input logic [3:0] idx,
                     input logic [2:0] tg, input logic [1:0] rv,
                     input logic [2:0] t0, input logic [2:0] t1,
                     input logic [1:0] rh);
    int ph;
    int ew, el;
    @(negedge clk);
    iss_vld_i = iv;
    iss_pc_i  = {lfsr, 10'h0, idx, 2'b01};
    iss_tag_i = tg;
    res_vld_i = rv;
    res_tag_i = {t1, t0};
    res_hit_i = rh;
    #1;
    ph = (mctr[idx] >= 2) ? 1 : 0;
    ew = iv ? ph : 0;
    el = iv ? (ph ? 3 : 5) : 0;
    // R2 R5 R6 R11: wakeup follows the trained counter
    check(first ? "R1 wake" : "R2 R5 R6 R11 wake", int'(spec_wake_o), ew);
    check(first ? "R1 lat" : "R3 R4 lat", int'(lat_o), el);
    // R7 R8 R9 R10: replay window
    check("R7 R8 R9 R10 replay", int'(replay_o), (mrep > 0) ? 1 : 0);
    @(posedge clk);
    begin
      bit bad;
      bad = 1'b0;
      if (rv[0]) begin
        if (mpred[t0] != 0 && !rh[0]) bad = 1'b1;
        mctr[midx[t0]] = rh[0] ? ((mctr[midx[t0]] < 3) ? mctr[midx[t0]] + 1 : 3)
                               : ((mctr[midx[t0]] > 0) ? mctr[midx[t0]] - 1 : 0);
      end
      if (rv[1]) begin
        if (mpred[t1] != 0 && !rh[1]) bad = 1'b1;
        mctr[midx[t1]] = rh[1] ? ((mctr[midx[t1]] < 3) ? mctr[midx[t1]] + 1 : 3)
                               : ((mctr[midx[t1]] > 0) ? mctr[midx[t1]] - 1 : 0);
      end
      if (iv) begin
        mpred[tg] = ph;
        midx[tg]  = int'(idx);
      end
      mrep = bad ? 2 : ((mrep > 0) ? mrep - 1 : 0);
    end
  endtask

  initial begin
    #3_000_000;
    n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [3:0] idx_of [1600];
    logic       hit_of [1600];
    rst_n = 1'b0;
    iss_vld_i = 1'b0; iss_pc_i = '0; iss_tag_i = '0;
    res_vld_i = '0; res_tag_i = '0; res_hit_i = '0;
    for (int i = 0; i < 16; i++) mctr[i] = 2;
    for (int i = 0; i < 8; i++) begin mpred[i] = 0; midx[i] = 0; end
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1: every index predicts a hit right after reset
    for (int i = 0; i < 16; i++)
      cyc(1'b1, 1'b1, 4'(i), 3'(i % 8), 2'b00, 3'd0, 3'd0, 2'b00);

    // sweep: even-numbered loads resolve 3 cycles later on lane 0,
    // odd-numbered loads 2 cycles later on lane 1
    for (int c = 0; c < 1600; c++) begin
      logic [3:0] ix;
      logic       h;
      int         pct;
      lfsr_step();
      if (c < 400)       ix = lfsr[0] ? 4'd5 : 4'd6;
      else if (c < 1200) ix = lfsr[3:0];
      else               ix = 4'd9;
      pct = int'(lfsr[7:4]);
      if (c < 400)       h = (pct < 8);
      else if (c < 800)  h = (pct < 4);
      else if (c < 1200) h = (pct < 12);
      else               h = ((c / 6) % 2 == 0) ? (pct < 14) : (pct < 2);
      idx_of[c] = ix;
      hit_of[c] = h;
    end
    for (int c = 0; c < 1604; c++) begin
      logic       iv;
      logic [1:0] rv, rh;
      logic [2:0] t0, t1;
      iv = (c < 1600);
      rv = 2'b00; rh = 2'b00; t0 = 3'd0; t1 = 3'd0;
      if ((c % 2 == 1) && c >= 3 && (c - 3) < 1600) begin
        rv[0] = 1'b1; t0 = 3'((c - 3) % 8); rh[0] = hit_of[c - 3];
      end
      if ((c % 2 == 1) && (c - 2) < 1600) begin
        rv[1] = 1'b1; t1 = 3'((c - 2) % 8); rh[1] = hit_of[c - 2];
      end
      cyc(1'b0, iv, iv ? idx_of[c] : 4'd0, 3'(c % 8), rv, t0, t1, rh);
    end
    cyc(1'b0, 1'b0, 4'd0, 3'd0, 2'b00, 3'd0, 3'd0, 2'b00);
    cyc(1'b0, 1'b0, 4'd0, 3'd0, 2'b00, 3'd0, 3'd0, 2'b00);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule